// File: doc/BRIEF.md
# Reference-Counted Instruction Block Buffer

This block sits between an in-order fetch stage and an instruction memory port. It keeps a few whole instruction blocks and a table of block misses still in flight. Every entry, in either store, counts the fetches that still wait on it. A fetch names an address-space tag and a byte address. A repeat fetch of a block that is already buffered or already in flight shares that entry and causes no new memory read. A fetch that finds nothing starts exactly one block read.

The fetch stage talks to the block in three steps: start a fetch, finish a fetch, or squash a fetch. A start reply says whether the fetch will later be served from the buffer or from its own miss. The fetch stage hands that flag back when it finishes the fetch. A finish returns the selected 32-bit word, or asks for a retry when the data is not there yet. The memory side is a plain request port and a response port that carries a full block. A flush input empties both stores at once.

Top module: `fetch_refbuf`

## Requirements
- R1: An entry serves a fetch only when both its address-space tag and its block address (address bits above the in-block offset, 64-byte blocks by default) equal the fetch's. The same block address under another tag is a separate miss that has its own data.
- R2: A start (cmd_op = 0) whose block is in the miss table is accepted in the same cycle with rsp_ok = 1 and rsp_via_buf = 1. It raises no memory request and adds one waiter to that miss entry. This holds even when the buffer is at capacity.
- R3: The buffer is searched on a start only while occupancy is below capacity. Occupancy is the number of miss entries plus the number of buffer entries with a nonzero waiter count. A buffer hit answers rsp_ok = 1 and rsp_via_buf = 1, with no memory request. At full occupancy, a start whose block is buffered is refused.
- R4: A start that hits nothing while occupancy is at or above capacity is refused with rsp_stall = 1 and rsp_ok = 0, and no memory request is raised.
- R5: A start that misses while there is room raises mem_req_valid in the same cycle. The request carries the block-aligned address and the fetch's tag. The reply is rsp_ok = 1 with rsp_via_buf = 0, and a miss entry is created with one waiter.
- R6: A memory response fills the matching miss entry. A finish of that miss stalls (rsp_stall = 1) until the response has been captured on an earlier clock edge.
- R7: A finish with cmd_via_buf = 0 (cmd_op = 1) moves the filled miss entry into the buffer with one waiter fewer, as most recently used. It returns the word at index address bits [5:2]. When the buffer is full, the evicted entry is the least recently used one among those with zero waiters, and busy entries are skipped even when they are older.
- R8: A finish with cmd_via_buf = 1 stalls while its block is not in the buffer. Otherwise it returns the word at index address bits [5:2], removes one waiter and marks the entry most recently used.
- R9: A squash (cmd_op = 2) removes one waiter from the matching buffer entry, if there is one. Otherwise it removes one waiter from the matching miss entry and deletes that miss entry when no waiter is left.
- R10: A command with cmd_fault = 1 returns rsp_ok = 1 and rsp_fault = 1. It raises no memory request and leaves both stores unchanged.
- R11: Reset and the flush input empty the buffer and the miss table. After a flush, every block misses again.
- R12: A memory response in the same cycle as a squash that deletes its miss entry is discarded. A response in the same cycle as a finish of that miss leaves the finish stalled, with the data kept for the next try. A response in the same cycle as a merging start keeps both effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empties both stores; overrides any command that cycle |
| cmd_valid | input | 1 | A command is presented |
| cmd_op | input | 2 | 0 start, 1 finish, 2 squash, 3 no operation |
| cmd_asid | input | 8 | Address-space tag of the fetch |
| cmd_addr | input | 32 | Byte address of the fetch |
| cmd_via_buf | input | 1 | On a finish: the start reply said "served from buffer" |
| cmd_fault | input | 1 | The fetch already carries a fault |
| rsp_ok | output | 1 | Command accepted this cycle |
| rsp_stall | output | 1 | Command refused; the fetch stage retries it |
| rsp_via_buf | output | 1 | On a start: the fetch will be served from the buffer |
| rsp_fault | output | 1 | Fault passed straight through |
| rsp_word | output | 32 | Selected instruction word on an accepted finish |
| mem_req_valid | output | 1 | Block read request |
| mem_req_asid | output | 8 | Tag of the requested block |
| mem_req_addr | output | 32 | Block-aligned address of the request |
| mem_rsp_valid | input | 1 | Block read data is returned |
| mem_rsp_asid | input | 8 | Tag of the returned block |
| mem_rsp_addr | input | 32 | Block address of the returned block |
| mem_rsp_data | input | 512 | Returned block, word 0 in the low bits |

## Verification
The memory response port works alongside the command port, so a block can return in the same cycle as a squash, a finish or a merging start for that block. The bench forces each of these collisions by placing the response on the port first and then issuing the command within the same clock period. It then judges what was kept from the ports alone. After a squash collision, a new start must raise a fresh memory request and its finish must stall, which shows the stale data was discarded. After a finish collision, the retry must return the right word. After a merge collision, both the miss finish and the buffered finish must return their words.

// File: rtl/fb_pkg.sv
// Shared encodings of the reference-counted fetch block buffer.
package fb_pkg;
    typedef enum logic [1:0] {
        FB_OP_START  = 2'd0,
        FB_OP_FINISH = 2'd1,
        FB_OP_SQUASH = 2'd2,
        FB_OP_NONE   = 2'd3
    } fb_op_e;
endpackage

// File: rtl/fb_match.sv
// Associative lookup: reports whether a key is held by any valid entry
// and the lowest index that holds it. Assumes keys are unique per table.
module fb_match #(
    parameter int N     = 4,
    parameter int KEY_W = 8,
    parameter int IW    = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]            ent_valid,
    input  logic [N-1:0][KEY_W-1:0] ent_key,
    input  logic [KEY_W-1:0]        key,
    output logic                    hit,
    output logic [IW-1:0]           idx
);
    // compare every entry, keep the lowest matching slot
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (ent_valid[i] && (ent_key[i] == key)) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/fb_lru.sv
// Recency ranks for the buffer slots: rank 0 is least recently used.
// A touch makes a slot most recent; slots ranked above it move down one.
// Assumes ent_valid is the slot valid vector before the same edge's update.
module fb_lru #(
    parameter int N  = 4,
    parameter int RW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          touch,
    input  logic [RW-1:0] touch_idx,
    input  logic [N-1:0]  ent_valid,
    input  logic [N-1:0]  elig,
    output logic          victim_ok,
    output logic [RW-1:0] victim_idx
);
    logic [N-1:0][RW-1:0] rank;
    logic [RW:0]          nvalid;
    logic [RW:0]          newtop;
    logic                 s_valid;
    logic [RW-1:0]        best;

    // new top rank: count after the touch minus one
    always_comb begin
        nvalid  = (RW + 1)'($countones(ent_valid));
        s_valid = ent_valid[touch_idx];
        newtop  = s_valid ? (nvalid - 1'b1) : nvalid;
    end

    // update ranks on each touch, clear them on reset or flush
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rank <= '0;
        end else if (touch) begin
            for (int i = 0; i < N; i++) begin
                if (i == int'(touch_idx)) begin
                    rank[i] <= newtop[RW-1:0];
                end else if (s_valid && ent_valid[i] && (rank[i] > rank[touch_idx])) begin
                    rank[i] <= rank[i] - 1'b1;
                end
            end
        end
    end

    // pick the eligible slot with the lowest rank
    always_comb begin
        victim_ok  = 1'b0;
        victim_idx = '0;
        best       = '1;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && (!victim_ok || (rank[i] < best))) begin
                victim_ok  = 1'b1;
                victim_idx = RW'(i);
                best       = rank[i];
            end
        end
    end

    // R7: each live slot holds a rank below the number of live slots
    for (genvar g = 0; g < N; g++) begin : g_rank_chk
        p_rank_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ent_valid[g] |-> ({1'b0, rank[g]} < nvalid));
    end
endmodule

// File: rtl/fetch_refbuf.sv
// Reference-counted instruction block buffer with a miss table.
// Starts merge onto in-flight misses or buffered blocks; finishes return
// one word; squashes release a waiter; flush empties everything.
// Assumes the memory port always accepts a request and returns a full block.
module fetch_refbuf
    import fb_pkg::*;
#(
    parameter int CAP       = 4,
    parameter int ASID_W    = 8,
    parameter int ADDR_W    = 32,
    parameter int WORD_W    = 32,
    parameter int BLK_WORDS = 16,
    parameter int CNT_W     = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic                          cmd_valid,
    input  logic [1:0]                    cmd_op,
    input  logic [ASID_W-1:0]             cmd_asid,
    input  logic [ADDR_W-1:0]             cmd_addr,
    input  logic                          cmd_via_buf,
    input  logic                          cmd_fault,
    output logic                          rsp_ok,
    output logic                          rsp_stall,
    output logic                          rsp_via_buf,
    output logic                          rsp_fault,
    output logic [WORD_W-1:0]             rsp_word,
    output logic                          mem_req_valid,
    output logic [ASID_W-1:0]             mem_req_asid,
    output logic [ADDR_W-1:0]             mem_req_addr,
    input  logic                          mem_rsp_valid,
    input  logic [ASID_W-1:0]             mem_rsp_asid,
    input  logic [ADDR_W-1:0]             mem_rsp_addr,
    input  logic [BLK_WORDS*WORD_W-1:0]   mem_rsp_data
);
    localparam int BLK_BITS = BLK_WORDS * WORD_W;
    localparam int OFS_LO   = $clog2(WORD_W / 8);
    localparam int WI_W     = $clog2(BLK_WORDS);
    localparam int TAG_LO   = OFS_LO + WI_W;
    localparam int TAG_W    = ADDR_W - TAG_LO;
    localparam int KEY_W    = ASID_W + TAG_W;
    localparam int IW       = (CAP > 1) ? $clog2(CAP) : 1;
    localparam int OW       = $clog2(2 * CAP + 1);

    // buffer store
    logic [CAP-1:0]                buf_v;
    logic [CAP-1:0][KEY_W-1:0]     buf_key;
    logic [CAP-1:0][CNT_W-1:0]     buf_cnt;
    logic [CAP-1:0][BLK_BITS-1:0]  buf_data;
    // miss table
    logic [CAP-1:0]                pnd_v;
    logic [CAP-1:0]                pnd_dv;
    logic [CAP-1:0][KEY_W-1:0]     pnd_key;
    logic [CAP-1:0][CNT_W-1:0]     pnd_cnt;
    logic [CAP-1:0][BLK_BITS-1:0]  pnd_data;

    logic [KEY_W-1:0] cmd_key, rsp_key;
    logic [WI_W-1:0]  widx;
    logic             bhit, phit, rhit;
    logic [IW-1:0]    bidx, pidx, ridx;
    logic [CAP-1:0]   busy, elig;
    logic [OW-1:0]    occ;
    logic             buf_full;
    logic             bfree_ok, pfree_ok;
    logic [IW-1:0]    bfree_idx, pfree_idx;
    logic             victim_ok;
    logic [IW-1:0]    victim_idx, dest;
    logic             a_pinc, a_binc, a_palloc, a_btake, a_move, a_bsq, a_psq;
    logic             addr_unused;

    assign addr_unused = ^{cmd_addr[OFS_LO-1:0], mem_rsp_addr[TAG_LO-1:0]};

    // keys and word index of the command and of the memory response
    always_comb begin
        cmd_key = {cmd_asid, cmd_addr[ADDR_W-1:TAG_LO]};
        rsp_key = {mem_rsp_asid, mem_rsp_addr[ADDR_W-1:TAG_LO]};
        widx    = cmd_addr[TAG_LO-1:OFS_LO];
    end

    fb_match #(.N(CAP), .KEY_W(KEY_W), .IW(IW)) u_buf_match (
        .ent_valid(buf_v), .ent_key(buf_key), .key(cmd_key), .hit(bhit), .idx(bidx));
    fb_match #(.N(CAP), .KEY_W(KEY_W), .IW(IW)) u_pnd_match (
        .ent_valid(pnd_v), .ent_key(pnd_key), .key(cmd_key), .hit(phit), .idx(pidx));
    fb_match #(.N(CAP), .KEY_W(KEY_W), .IW(IW)) u_rsp_match (
        .ent_valid(pnd_v), .ent_key(pnd_key), .key(rsp_key), .hit(rhit), .idx(ridx));

    // occupancy, eviction candidates and free slots
    always_comb begin
        for (int i = 0; i < CAP; i++) begin
            busy[i] = buf_v[i] && (buf_cnt[i] != '0);
            elig[i] = buf_v[i] && (buf_cnt[i] == '0);
        end
        occ       = OW'($countones(pnd_v)) + OW'($countones(busy));
        buf_full  = &buf_v;
        bfree_ok  = 1'b0;
        bfree_idx = '0;
        pfree_ok  = 1'b0;
        pfree_idx = '0;
        for (int i = CAP - 1; i >= 0; i--) begin
            if (!buf_v[i]) begin
                bfree_ok  = 1'b1;
                bfree_idx = IW'(i);
            end
            if (!pnd_v[i]) begin
                pfree_ok  = 1'b1;
                pfree_idx = IW'(i);
            end
        end
    end

    fb_lru #(.N(CAP), .RW(IW)) u_lru (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .touch(a_btake || a_move), .touch_idx(a_move ? dest : bidx),
        .ent_valid(buf_v), .elig(elig),
        .victim_ok(victim_ok), .victim_idx(victim_idx));

    assign dest = buf_full ? victim_idx : bfree_idx;

    // decide the reply and the table actions of this cycle's command
    always_comb begin
        rsp_ok        = 1'b0;
        rsp_stall     = 1'b0;
        rsp_via_buf   = 1'b0;
        rsp_fault     = 1'b0;
        rsp_word      = '0;
        mem_req_valid = 1'b0;
        mem_req_asid  = cmd_asid;
        mem_req_addr  = {cmd_addr[ADDR_W-1:TAG_LO], {TAG_LO{1'b0}}};
        {a_pinc, a_binc, a_palloc, a_btake, a_move, a_bsq, a_psq} = '0;
        if (cmd_valid && !flush) begin
            if (cmd_fault) begin
                rsp_ok    = 1'b1;
                rsp_fault = 1'b1;
            end else begin
                case (cmd_op)
                    FB_OP_START: begin
                        if (phit) begin
                            a_pinc = 1'b1;
                            rsp_ok = 1'b1;
                            rsp_via_buf = 1'b1;
                        end else if ((occ < OW'(CAP)) && bhit) begin
                            a_binc = 1'b1;
                            rsp_ok = 1'b1;
                            rsp_via_buf = 1'b1;
                        end else if ((occ >= OW'(CAP)) || !pfree_ok) begin
                            rsp_stall = 1'b1;
                        end else begin
                            a_palloc = 1'b1;
                            rsp_ok = 1'b1;
                            mem_req_valid = 1'b1;
                        end
                    end
                    FB_OP_FINISH: begin
                        if (cmd_via_buf) begin
                            if (bhit) begin
                                a_btake  = 1'b1;
                                rsp_ok   = 1'b1;
                                rsp_word = buf_data[bidx][widx*WORD_W +: WORD_W];
                            end else begin
                                rsp_stall = 1'b1;
                            end
                        end else if (phit && pnd_dv[pidx] && (!buf_full || victim_ok)) begin
                            a_move   = 1'b1;
                            rsp_ok   = 1'b1;
                            rsp_word = pnd_data[pidx][widx*WORD_W +: WORD_W];
                        end else begin
                            rsp_stall = 1'b1;
                        end
                    end
                    FB_OP_SQUASH: begin
                        rsp_ok = 1'b1;
                        a_bsq  = bhit;
                        a_psq  = !bhit && phit;
                    end
                    default: ;
                endcase
            end
        end
    end

    // buffer control state: valid bits, keys and waiter counts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_v   <= '0;
            buf_cnt <= '0;
            buf_key <= '0;
        end else if (flush) begin
            buf_v   <= '0;
            buf_cnt <= '0;
        end else begin
            if (a_binc && (buf_cnt[bidx] != '1))
                buf_cnt[bidx] <= buf_cnt[bidx] + 1'b1;
            if ((a_btake || a_bsq) && (buf_cnt[bidx] != '0))
                buf_cnt[bidx] <= buf_cnt[bidx] - 1'b1;
            if (a_move) begin
                buf_v[dest]   <= 1'b1;
                buf_key[dest] <= pnd_key[pidx];
                buf_cnt[dest] <= pnd_cnt[pidx] - 1'b1;
            end
        end
    end

    // buffer block data, written when a miss moves in
    always_ff @(posedge clk) begin
        if (a_move)
            buf_data[dest] <= pnd_data[pidx];
    end

    // miss table control: allocation, merging, fill flags and removal
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pnd_v   <= '0;
            pnd_dv  <= '0;
            pnd_cnt <= '0;
            pnd_key <= '0;
        end else if (flush) begin
            pnd_v  <= '0;
            pnd_dv <= '0;
        end else begin
            if (mem_rsp_valid && rhit)
                pnd_dv[ridx] <= 1'b1;
            if (a_pinc && (pnd_cnt[pidx] != '1))
                pnd_cnt[pidx] <= pnd_cnt[pidx] + 1'b1;
            if (a_palloc) begin
                pnd_v[pfree_idx]   <= 1'b1;
                pnd_dv[pfree_idx]  <= 1'b0;
                pnd_key[pfree_idx] <= cmd_key;
                pnd_cnt[pfree_idx] <= CNT_W'(1);
            end
            if (a_move) begin
                pnd_v[pidx]  <= 1'b0;
                pnd_dv[pidx] <= 1'b0;
            end
            if (a_psq) begin
                if (pnd_cnt[pidx] <= CNT_W'(1)) begin
                    pnd_v[pidx]  <= 1'b0;
                    pnd_dv[pidx] <= 1'b0;
                end else begin
                    pnd_cnt[pidx] <= pnd_cnt[pidx] - 1'b1;
                end
            end
        end
    end

    // miss table block data, captured from the memory response
    always_ff @(posedge clk) begin
        if (mem_rsp_valid && rhit && !flush)
            pnd_data[ridx] <= mem_rsp_data;
    end

    // R9: a waiter is never released from a buffer entry that has none
    p_cnt_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (a_bsq || a_btake) |-> (buf_cnt[bidx] != '0));
    // R4: occupancy never exceeds capacity
    p_occ_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OW'(CAP));
    // R4: a refused command neither reads memory nor reports success
    p_stall_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_stall |-> (!mem_req_valid && !rsp_ok));
    // R2: merging onto an in-flight miss starts no read
    p_merge_noread_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_fault && (cmd_op == FB_OP_START) && phit) |-> !mem_req_valid);
    // R7: a filled miss finding a full buffer always has a zero-count entry
    p_victim_avail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !flush && !cmd_fault && (cmd_op == FB_OP_FINISH) && !cmd_via_buf
         && phit && pnd_dv[pidx] && buf_full) |-> victim_ok);
    // R11: flush leaves both stores empty on the next cycle
    p_flush_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ((buf_v == '0) && (pnd_v == '0)));
endmodule

// File: tb/fetch_refbuf_tb.sv
// Directed bench for the reference-counted fetch block buffer.
module fetch_refbuf_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         flush = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [1:0]   cmd_op = 2'd3;
    logic [7:0]   cmd_asid = '0;
    logic [31:0]  cmd_addr = '0;
    logic         cmd_via_buf = 1'b0;
    logic         cmd_fault = 1'b0;
    logic         rsp_ok, rsp_stall, rsp_via_buf, rsp_fault;
    logic [31:0]  rsp_word;
    logic         mem_req_valid;
    logic [7:0]   mem_req_asid;
    logic [31:0]  mem_req_addr;
    logic         mem_rsp_valid = 1'b0;
    logic [7:0]   mem_rsp_asid = '0;
    logic [31:0]  mem_rsp_addr = '0;
    logic [511:0] mem_rsp_data = '0;

    int total = 0;
    int bad = 0;
    logic        c_ok, c_stall, c_via, c_fault, c_mreq;
    logic [31:0] c_word, c_maddr;
    logic [7:0]  c_masid;

    always #5 clk = ~clk;

    fetch_refbuf dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_asid(cmd_asid), .cmd_addr(cmd_addr),
        .cmd_via_buf(cmd_via_buf), .cmd_fault(cmd_fault),
        .rsp_ok(rsp_ok), .rsp_stall(rsp_stall), .rsp_via_buf(rsp_via_buf),
        .rsp_fault(rsp_fault), .rsp_word(rsp_word),
        .mem_req_valid(mem_req_valid), .mem_req_asid(mem_req_asid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_asid(mem_rsp_asid),
        .mem_rsp_addr(mem_rsp_addr), .mem_rsp_data(mem_rsp_data));

    function automatic logic [31:0] exp_word(input logic [7:0] a, input logic [31:0] addr);
        return {a, addr[23:6], 2'b00, addr[5:2]};
    endfunction

    function automatic logic [511:0] blk_data(input logic [7:0] a, input logic [31:0] blk);
        logic [511:0] d;
        for (int w = 0; w < 16; w++) d[w*32 +: 32] = {a, blk[23:6], 2'b00, w[3:0]};
        return d;
    endfunction

    task automatic chk(input bit cond, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // drive one command for one cycle and capture the combinational reply
    task automatic issue(input logic [1:0] op, input logic [7:0] a, input logic [31:0] addr,
                         input logic via, input logic flt);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_asid = a; cmd_addr = addr;
        cmd_via_buf = via; cmd_fault = flt;
        #1;
        c_ok = rsp_ok; c_stall = rsp_stall; c_via = rsp_via_buf; c_fault = rsp_fault;
        c_word = rsp_word; c_mreq = mem_req_valid; c_maddr = mem_req_addr; c_masid = mem_req_asid;
        @(posedge clk); #1;
        cmd_valid = 1'b0; cmd_fault = 1'b0; mem_rsp_valid = 1'b0;
    endtask

    // place a memory response so it lands on the next command's edge
    task automatic arm(input logic [7:0] a, input logic [31:0] blk);
        mem_rsp_valid = 1'b1; mem_rsp_asid = a; mem_rsp_addr = blk;
        mem_rsp_data = blk_data(a, blk);
    endtask

    task automatic fill(input logic [7:0] a, input logic [31:0] blk);
        @(negedge clk);
        arm(a, blk);
        @(posedge clk); #1;
        mem_rsp_valid = 1'b0;
    endtask

    task automatic exp_miss(input string req, input logic [7:0] a, input logic [31:0] addr);
        issue(2'd0, a, addr, 1'b0, 1'b0);
        chk(c_ok && !c_via && c_mreq && (c_maddr == {addr[31:6], 6'b0}) && (c_masid == a),
            req, "start miss {ok,via,mreq},addr", {c_ok, c_via, c_mreq, c_maddr[28:0]},
            {3'b101, addr[28:6], 6'b0});
    endtask

    task automatic exp_merge(input string req, input logic [7:0] a, input logic [31:0] addr);
        issue(2'd0, a, addr, 1'b0, 1'b0);
        chk(c_ok && c_via && !c_mreq && !c_stall, req, "start merge {ok,via,mreq,stall}",
            {28'b0, c_ok, c_via, c_mreq, c_stall}, 32'hC);
    endtask

    task automatic exp_refuse(input string req, input logic [7:0] a, input logic [31:0] addr);
        issue(2'd0, a, addr, 1'b0, 1'b0);
        chk(!c_ok && c_stall && !c_mreq, req, "start refused {ok,stall,mreq}",
            {29'b0, c_ok, c_stall, c_mreq}, 32'h2);
    endtask

    task automatic fin(input string req, input logic [7:0] a, input logic [31:0] addr,
                       input logic via);
        issue(2'd1, a, addr, via, 1'b0);
        chk(c_ok && !c_stall && (c_word == exp_word(a, addr)), req, "finish word",
            c_word, exp_word(a, addr));
    endtask

    task automatic fin_stall(input string req, input logic [7:0] a, input logic [31:0] addr,
                             input logic via);
        issue(2'd1, a, addr, via, 1'b0);
        chk(!c_ok && c_stall, req, "finish stalls {ok,stall}", {30'b0, c_ok, c_stall}, 32'h1);
    endtask

    task automatic squash(input logic [7:0] a, input logic [31:0] addr);
        issue(2'd2, a, addr, 1'b0, 1'b0);
    endtask

    task automatic t_reset;
        @(negedge clk); #1;
        chk(!rsp_ok && !rsp_stall && !mem_req_valid, "R11", "idle after reset",
            {29'b0, rsp_ok, rsp_stall, mem_req_valid}, 32'h0);
    endtask

    task automatic t_merge_miss;
        exp_miss("R5", 8'h01, 32'h1008);
        exp_merge("R2", 8'h01, 32'h1004);
        fin_stall("R6", 8'h01, 32'h1008, 1'b0);
        fill(8'h01, 32'h1000);
        fin("R7", 8'h01, 32'h1008, 1'b0);
        fin("R8", 8'h01, 32'h1004, 1'b1);
        fin_stall("R8", 8'h01, 32'hF000, 1'b1);
    endtask

    task automatic t_asid;
        exp_miss("R1", 8'h02, 32'h1000);
        fill(8'h02, 32'h1000);
        fin("R1", 8'h02, 32'h1000, 1'b0);
        exp_miss("R5", 8'h01, 32'h1040);
        fill(8'h01, 32'h1040);
        fin("R7", 8'h01, 32'h1040, 1'b0);
    endtask

    task automatic t_buf_hit;
        exp_merge("R3", 8'h01, 32'h103C);
        fin("R8", 8'h01, 32'h103C, 1'b1);
    endtask

    task automatic t_evict;
        exp_miss("R5", 8'h01, 32'h2000); fill(8'h01, 32'h2000); fin("R7", 8'h01, 32'h2000, 1'b0);
        exp_miss("R5", 8'h01, 32'h3000); fill(8'h01, 32'h3000); fin("R7", 8'h01, 32'h3000, 1'b0);
        exp_miss("R7", 8'h02, 32'h1000);
        squash(8'h02, 32'h1000);
        exp_miss("R9", 8'h02, 32'h1000);
        squash(8'h02, 32'h1000);
        exp_merge("R7", 8'h01, 32'h1000);
        fin("R8", 8'h01, 32'h1000, 1'b1);
    endtask

    task automatic t_busy_skip;
        exp_merge("R3", 8'h01, 32'h1040);
        exp_merge("R3", 8'h01, 32'h2000);
        exp_merge("R3", 8'h01, 32'h3000);
        exp_miss("R5", 8'h01, 32'h4000);
        exp_refuse("R4", 8'h01, 32'h5000);
        exp_refuse("R3", 8'h01, 32'h1000);
        exp_merge("R2", 8'h01, 32'h4004);
        fill(8'h01, 32'h4000);
        fin("R7", 8'h01, 32'h4000, 1'b0);
        fin("R8", 8'h01, 32'h4004, 1'b1);
        fin("R8", 8'h01, 32'h1040, 1'b1);
        fin("R8", 8'h01, 32'h2000, 1'b1);
        fin("R8", 8'h01, 32'h3000, 1'b1);
        exp_miss("R7", 8'h01, 32'h1000);
        exp_merge("R7", 8'h01, 32'h1040);
        fin("R8", 8'h01, 32'h1040, 1'b1);
        squash(8'h01, 32'h1000);
    endtask

    task automatic t_squash_buf;
        exp_merge("R9", 8'h01, 32'h1040);
        exp_merge("R9", 8'h01, 32'h2000);
        exp_merge("R9", 8'h01, 32'h3000);
        squash(8'h01, 32'h1040);
        chk(c_ok, "R9", "squash accepted", {31'b0, c_ok}, 32'h1);
        exp_merge("R9", 8'h01, 32'h4000);
        exp_miss("R9", 8'h01, 32'h6000);
        squash(8'h01, 32'h6000);
        fin("R8", 8'h01, 32'h2000, 1'b1);
        fin("R8", 8'h01, 32'h3000, 1'b1);
        fin("R8", 8'h01, 32'h4000, 1'b1);
    endtask

    task automatic t_fault;
        issue(2'd0, 8'h01, 32'hA000, 1'b0, 1'b1);
        chk(c_ok && c_fault && !c_mreq && !c_stall, "R10", "fault start {ok,fault,mreq,stall}",
            {28'b0, c_ok, c_fault, c_mreq, c_stall}, 32'hC);
        exp_miss("R10", 8'h01, 32'hA000);
        squash(8'h01, 32'hA000);
        issue(2'd1, 8'h01, 32'hF000, 1'b1, 1'b1);
        chk(c_ok && c_fault && !c_stall, "R10", "fault finish {ok,fault,stall}",
            {29'b0, c_ok, c_fault, c_stall}, 32'h6);
    endtask

    task automatic t_collide;
        exp_miss("R12", 8'h01, 32'h7000);
        arm(8'h01, 32'h7000);
        squash(8'h01, 32'h7000);
        exp_miss("R12", 8'h01, 32'h7000);
        fin_stall("R12", 8'h01, 32'h7000, 1'b0);
        fill(8'h01, 32'h7000);
        fin("R12", 8'h01, 32'h7000, 1'b0);
        exp_miss("R12", 8'h01, 32'h8000);
        arm(8'h01, 32'h8000);
        fin_stall("R12", 8'h01, 32'h8000, 1'b0);
        fin("R12", 8'h01, 32'h8000, 1'b0);
        exp_miss("R12", 8'h01, 32'h9000);
        arm(8'h01, 32'h9000);
        exp_merge("R12", 8'h01, 32'h9010);
        fin("R12", 8'h01, 32'h9000, 1'b0);
        fin("R12", 8'h01, 32'h9010, 1'b1);
    endtask

    task automatic t_flush;
        exp_merge("R11", 8'h01, 32'h9000);
        exp_miss("R11", 8'h01, 32'hB000);
        @(negedge clk); flush = 1'b1;
        @(posedge clk); #1; flush = 1'b0;
        exp_miss("R11", 8'h01, 32'hB000);
        exp_miss("R11", 8'h01, 32'h9000);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_merge_miss();
        t_asid();
        t_buf_hit();
        t_evict();
        t_busy_skip();
        t_squash_buf();
        t_fault();
        t_collide();
        t_flush();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule